// File: doc/BRIEF.md
# Pulse-Handshake I/O Responder

This block sits on the device side of a small processor's byte-wide I/O port and stands in for a peripheral that answers after a chosen delay. The processor raises a read request or a write request for exactly one clock cycle. The responder must therefore remember that a transaction is pending. After the delay chosen for that transaction, it answers with a one-cycle acknowledge. On a read, the byte returned is valid only during the acknowledge cycle; at all other times the read data bus is driven to zero. On a write, the byte on the write data bus is taken in the request cycle and kept in a register that can be read at any time.

Each direction is served by its own channel, and the two channels run independently. A channel state machine has three states. `CH_IDLE` waits for a request. `CH_WAIT` counts down the latched delay. `CH_ACK` drives the acknowledge for one cycle. The transitions are:
- **accept-short**: `CH_IDLE`→`CH_ACK`, on a request with an effective delay of 1.
- **accept-long**: `CH_IDLE`→`CH_WAIT`, on a request with a longer delay.
- **expire**: `CH_WAIT`→`CH_ACK`, when the countdown reaches its last cycle.
- **release**: `CH_ACK`→`CH_IDLE`, always.

Requests that arrive outside `CH_IDLE` are dropped. The block is used in benches to exercise a processor's I/O stall logic under varied response timing.

Top module: `pulse_io_responder`

## Requirements
- R1: After reset, rd_ack and wr_ack are low, rd_data is 0x00 and last_wr is 0x00.
- R2: A read request accepted in cycle n with effective delay D gives rd_ack high in cycle n+D only, for exactly one cycle.
- R3: A write request accepted in cycle n with effective delay D gives wr_ack high in cycle n+D only, for exactly one cycle.
- R4: During the rd_ack cycle, rd_data equals the rd_fill byte sampled in the accepted request cycle; in every other cycle rd_data is 0x00.
- R5: last_wr takes the wr_data byte sampled in the accepted write request cycle (visible from the next cycle) and changes at no other time.
- R6: A request arriving while its channel is waiting or acknowledging is ignored: no extra acknowledge, and no change to the pending delay, the returned byte or last_wr.
- R7: A delay input of 0 is treated as 1, so the acknowledge comes in the cycle after the request.
- R8: The read and write channels are independent; simultaneous requests each complete on their own delay.
- R9: The delay is sampled only in the accepted request cycle; later changes on rd_lat or wr_lat do not move a pending acknowledge.
- R10: A new request in the cycle after an acknowledge is accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | One-cycle read request from the processor |
| rd_lat | input | LAT_W | Read response delay in cycles (0 means 1) |
| rd_fill | input | DATA_W | Byte to return, sampled with the read request |
| rd_ack | output | 1 | One-cycle read acknowledge |
| rd_data | output | DATA_W | Returned byte, zero outside the acknowledge cycle |
| wr_req | input | 1 | One-cycle write request from the processor |
| wr_lat | input | LAT_W | Write response delay in cycles (0 means 1) |
| wr_data | input | DATA_W | Byte written, valid in the request cycle |
| wr_ack | output | 1 | One-cycle write acknowledge |
| last_wr | output | DATA_W | Last byte captured from an accepted write |

## Verification
Each acknowledge is due exactly D cycles after the cycle in which its request was sampled, where D is the effective delay (at least 1). last_wr is due one cycle after acceptance. Each time the driver issues a request, it records the exact cycle in which the matching acknowledge must appear, along with its byte. The monitor samples on the falling edge, tags each acknowledge with the bench's cycle count, and compares it against the head of the queue, so an early, late or extra acknowledge fails. The falling-edge sampling also checks that rd_data is zero outside the acknowledge cycle. Ignored requests push nothing to the queue, so any response to them is reported.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_ACK  = 2'd2
    } ch_state_t;
endpackage

// File: rtl/pio_timer.sv
module pio_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             expire
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == LAT_W'(1));
endmodule

// File: rtl/pio_channel.sv
module pio_channel
    import pio_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LAT_W-1:0] lat,
    output logic             accept,
    output logic             ack
);
    ch_state_t        state_q, state_d;
    logic [LAT_W-1:0] eff_lat;
    logic             expire;

    assign eff_lat = (lat == '0) ? LAT_W'(1) : lat;

    pio_timer #(.LAT_W(LAT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (eff_lat - 1'b1),
        .expire   (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (req) state_d = (eff_lat == LAT_W'(1)) ? CH_ACK : CH_WAIT;
            CH_WAIT: if (expire) state_d = CH_ACK;
            CH_ACK:  state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        accept = (state_q == CH_IDLE) && req;
        ack    = (state_q == CH_ACK);
    end

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_expire_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT && expire) |=> ack);
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT && !expire) |=> (state_q == CH_WAIT));
    p_leave_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q != CH_IDLE));
endmodule

// File: rtl/pulse_io_responder.sv
module pulse_io_responder #(
    parameter int LAT_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [LAT_W-1:0]  rd_lat,
    input  logic [DATA_W-1:0] rd_fill,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic [LAT_W-1:0]  wr_lat,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    output logic [DATA_W-1:0] last_wr
);
    logic              rd_acc, wr_acc;
    logic [DATA_W-1:0] rd_hold_q;

    pio_channel #(.LAT_W(LAT_W)) u_rd_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (rd_req),
        .lat    (rd_lat),
        .accept (rd_acc),
        .ack    (rd_ack)
    );

    pio_channel #(.LAT_W(LAT_W)) u_wr_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (wr_req),
        .lat    (wr_lat),
        .accept (wr_acc),
        .ack    (wr_ack)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hold_q <= '0;
            last_wr   <= '0;
        end else begin
            if (rd_acc) rd_hold_q <= rd_fill;
            if (wr_acc) last_wr   <= wr_data;
        end
    end

    assign rd_data = rd_ack ? rd_hold_q : '0;

    p_rd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |-> (rd_data == '0));
    p_wr_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (last_wr == $past(wr_data)));
    p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(last_wr));
endmodule

// File: tb/test_pulse_io_responder.sv
module test_pulse_io_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req = 1'b0, wr_req = 1'b0;
    logic [3:0] rd_lat = '0, wr_lat = '0;
    logic [7:0] rd_fill = '0, wr_data = '0;
    logic       rd_ack, wr_ack;
    logic [7:0] rd_data, last_wr;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int rd_q_cyc[$], wr_q_cyc[$];
    logic [7:0] rd_q_dat[$], wr_q_dat[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_io_responder i_pulse_io_responder (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_lat(rd_lat), .rd_fill(rd_fill),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_lat(wr_lat), .wr_data(wr_data),
        .wr_ack(wr_ack), .last_wr(last_wr)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int eff(input logic [3:0] l);
        return (l == 0) ? 1 : int'(l);
    endfunction

    // driver: one-cycle read pulse; push=1 records the expected response
    task automatic send_rd(input logic [3:0] l, input logic [7:0] b, input bit push);
        @(negedge clk);
        rd_req = 1'b1; rd_lat = l; rd_fill = b;
        if (push) begin rd_q_cyc.push_back(cyc + eff(l)); rd_q_dat.push_back(b); end
        @(negedge clk);
        rd_req = 1'b0; rd_lat = 4'hF; rd_fill = 8'hEE;
    endtask

    task automatic send_wr(input logic [3:0] l, input logic [7:0] b, input bit push);
        @(negedge clk);
        wr_req = 1'b1; wr_lat = l; wr_data = b;
        if (push) begin wr_q_cyc.push_back(cyc + eff(l)); wr_q_dat.push_back(b); end
        @(negedge clk);
        wr_req = 1'b0; wr_lat = 4'hF; wr_data = 8'hDD;
    endtask

    task automatic drain();
        while (rd_q_cyc.size() != 0 || wr_q_cyc.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // monitor: scoreboard compare at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_ack) begin
                if (rd_q_cyc.size() == 0) check("R2 R6 unexpected rd_ack", 1, 0);
                else begin
                    check("R2 rd_ack cycle", cyc, rd_q_cyc.pop_front());
                    check("R4 rd_data in ack", rd_data, rd_q_dat.pop_front());
                end
            end else if (rd_data !== 8'h00) check("R4 rd_data idle", rd_data, 0);
            if (wr_ack) begin
                if (wr_q_cyc.size() == 0) check("R3 R6 unexpected wr_ack", 1, 0);
                else begin
                    check("R3 wr_ack cycle", cyc, wr_q_cyc.pop_front());
                    check("R5 last_wr at ack", last_wr, wr_q_dat.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_ack reset", rd_ack, 0);
        check("R1 wr_ack reset", wr_ack, 0);
        check("R1 rd_data reset", rd_data, 0);
        check("R1 last_wr reset", last_wr, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send_rd(4'd1, 8'hA5, 1); drain();          // R2 R4 shortest delay
        send_rd(4'd5, 8'h5A, 1); drain();          // R2 longer delay
        send_rd(4'd0, 8'h81, 1); drain();          // R7 zero means one
        send_wr(4'd0, 8'h42, 1); drain();          // R7 R3 write
        send_wr(4'd3, 8'h3C, 1); drain();          // R3 R5
        check("R5 last_wr held", last_wr, 8'h3C);

        // R6 R9: second read while waiting, with new delay and byte
        send_rd(4'd4, 8'h11, 1); send_rd(4'd1, 8'h22, 0); drain();
        // R6: write during waiting must not touch last_wr
        send_wr(4'd4, 8'h77, 1); send_wr(4'd1, 8'hFF, 0); drain();
        check("R6 last_wr after ignored write", last_wr, 8'h77);
        // R6: request in the ack cycle ignored, R10 next accepted
        send_wr(4'd2, 8'h19, 1); send_wr(4'd1, 8'hAB, 0);
        send_wr(4'd2, 8'h2E, 1); drain();
        check("R10 last_wr after back-to-back", last_wr, 8'h2E);
        send_rd(4'd1, 8'h61, 1); send_rd(4'd3, 8'h62, 1); drain(); // R10

        // R8: simultaneous read and write
        @(negedge clk);
        rd_req = 1; rd_lat = 4'd2; rd_fill = 8'hC3;
        wr_req = 1; wr_lat = 4'd6; wr_data = 8'h9D;
        rd_q_cyc.push_back(cyc + 2); rd_q_dat.push_back(8'hC3);
        wr_q_cyc.push_back(cyc + 6); wr_q_dat.push_back(8'h9D);
        @(negedge clk);
        rd_req = 0; wr_req = 0; rd_lat = 0; wr_lat = 0;
        drain();
        check("R8 last_wr after concurrent", last_wr, 8'h9D);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule